// File: doc/BRIEF.md
# Wide Register Atomic Byte Access Buffer

This block sits between a byte-wide serial register port and a set of internal registers that are 16 or 24 bits wide. Each wide register takes two or three consecutive byte addresses. The byte at the base address is the low byte. For a 24-bit register the next address is the middle byte and the one after it is the high byte. For a 16-bit register the address after the base is the high byte. A wide register is read or written one byte at a time, and this block keeps it consistent while that happens.

A read of the low byte takes a snapshot of the whole register. The middle and high bytes that follow come from that snapshot, even if the live value changes in the meantime. A write of the low byte opens an assembly buffer. The register receives the full value in a single-cycle commit strobe once its high byte arrives. A bus STOP discards any pending snapshot or partial write. Addresses outside the wide-register map pass straight through to the single-byte register file.

The address map is a parameter table. `BASE_MAP` holds one base address per register and `SIZE_MAP` holds a byte count (2 or 3) per register. Live values arrive as one 24-bit slot per register, and a 16-bit register uses the low 16 bits of its slot.

Top module: `wide_byte_access`

## Requirements
- R1: Wide register i occupies addresses BASE_MAP[i] through BASE_MAP[i]+SIZE_MAP[i]-1. Position 0 is the low byte (value bits 7:0), position 1 is bits 15:8 and position 2 is bits 23:16. The default map is register 0 at 0x10 (3 bytes), register 1 at 0x20 (2 bytes) and register 2 at 0x30 (3 bytes).
- R2: A read of a low byte returns that byte of the live value in the same cycle. It also captures the whole live register as the pending snapshot.
- R3: While a snapshot of register i is pending, a read of its middle or high byte returns the captured byte, not the live one.
- R4: A read of the high byte of the snapshotted register ends the snapshot. A middle or high byte read with no snapshot pending for that register returns the live byte.
- R5: A read of the low byte of another wide register replaces the pending snapshot with that register's value.
- R6: A write of a low byte starts assembly for that register. The following bytes must be written in ascending address order. The cycle after the high byte write, `commit_valid` is high for exactly one cycle, together with the register index and the full value (zero above the register's width).
- R7: No commit happens before every byte has arrived. A write to a middle or high byte that is not the next expected byte of the pending register is ignored, and the pending assembly stays as it was.
- R8: A STOP discards both the pending snapshot and any partial write. A STOP in the same cycle as the high byte write suppresses the commit.
- R9: A write of the low byte of another wide register drops the current assembly and restarts it for the new register.
- R10: For an address outside the map, `rd_data` equals `narrow_rdata` and `thru_wr` follows `bus_wr`. For an address inside the map, `thru_wr` is 0.
- R11: After reset no snapshot or assembly is pending and `commit_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the current access |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_stop | input | 1 | Bus STOP seen, one cycle |
| live_flat | input | NWIDE*24 | Live values, 24-bit slot per wide register |
| narrow_rdata | input | 8 | Read data from single-byte registers |
| rd_data | output | 8 | Read byte returned to the port |
| thru_wr | output | 1 | Write strobe for single-byte registers |
| commit_valid | output | 1 | One-cycle commit of a wide value |
| commit_idx | output | IDX_W | Index of the committed register |
| commit_value | output | 24 | Full committed value |

## Verification
Reads are exercised in four situations: with no snapshot pending, after the live value changes under a pending snapshot, after the snapshot has ended, and after another register's low byte replaces it. Together these separate held data from live data. Writes are driven in order, out of order, with no low byte first, interrupted by another register's low byte, and cut off by a STOP either before or during the high byte. Each case shows whether the commit waits for the complete, ordered value. Single-byte addresses and a reset in the middle of a sequence confirm the pass-through path and that reset leaves nothing pending.

// File: rtl/wab_pkg.sv
package wab_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned VAL_W  = 24;

  // Select byte p of a wide value.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [VAL_W-1:0] v,
                                                  input logic [1:0] p);
    return v[{p, 3'b000} +: BYTE_W];
  endfunction

  // Replace byte p of a wide value.
  function automatic logic [VAL_W-1:0] put_byte(input logic [VAL_W-1:0] v,
                                                input logic [1:0] p,
                                                input logic [BYTE_W-1:0] b);
    logic [VAL_W-1:0] r;
    r = v;
    r[{p, 3'b000} +: BYTE_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/wab_decode.sv
module wab_decode #(
  parameter int unsigned NWIDE  = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 2,
  parameter logic [NWIDE*ADDR_W-1:0] BASE_MAP = '0,
  parameter logic [NWIDE*2-1:0]      SIZE_MAP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        pos,
  output logic              last
);
  logic [NWIDE-1:0]  hit_vec;
  logic [ADDR_W-1:0] off_arr [NWIDE];
  logic [1:0]        size_arr [NWIDE];

  for (genvar i = 0; i < NWIDE; i++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = BASE_MAP[i*ADDR_W +: ADDR_W];
    localparam logic [1:0]        SZ   = SIZE_MAP[i*2 +: 2];
    assign off_arr[i]  = addr - BASE;
    assign size_arr[i] = SZ;
    assign hit_vec[i]  = off_arr[i] < ADDR_W'(SZ);
  end

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    pos  = 2'd0;
    last = 1'b0;
    for (int i = NWIDE - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        pos  = off_arr[i][1:0];
        last = (off_arr[i][1:0] == size_arr[i] - 2'd1);
      end
    end
  end

  // R1: windows of the map never overlap
  a_r1_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/wab_rd_snapshot.sv
module wab_rd_snapshot
  import wab_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_evt,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       pos,
  input  logic             last,
  input  logic             stop,
  input  logic [VAL_W-1:0] live_sel,
  output logic             held,
  output logic [VAL_W-1:0] snap_val
);
  logic             snap_pend;
  logic [IDX_W-1:0] snap_idx;
  logic             capture_evt;
  logic             release_evt;

  assign held        = snap_pend && (snap_idx == idx) && (pos != 2'd0);
  assign capture_evt = rd_evt && !stop && (pos == 2'd0);
  assign release_evt = rd_evt && !stop && held && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_pend <= 1'b0;
      snap_idx  <= '0;
      snap_val  <= '0;
    end else if (stop) begin
      snap_pend <= 1'b0;
    end else if (capture_evt) begin
      snap_pend <= 1'b1;
      snap_idx  <= idx;
      snap_val  <= live_sel;
    end else if (release_evt) begin
      snap_pend <= 1'b0;
    end
  end

  // R2: low-byte read captures the live value of the addressed register
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> snap_pend && snap_val == $past(live_sel) && snap_idx == $past(idx));
  // R3: held copy does not move without a new capture
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(snap_val));
  // R4: high-byte read closes the snapshot
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !snap_pend);
  // R8: STOP drops the snapshot
  a_r8_stop_read: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !snap_pend);
endmodule

// File: rtl/wab_wr_assembler.sv
module wab_wr_assembler
  import wab_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        pos,
  input  logic              last,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              stop,
  output logic              commit_valid,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [VAL_W-1:0]  commit_value
);
  logic             asm_pend;
  logic [IDX_W-1:0] asm_idx;
  logic [1:0]       asm_next;
  logic [VAL_W-1:0] asm_buf;
  logic             start_evt;
  logic             accept_evt;

  assign start_evt  = wr_evt && !stop && (pos == 2'd0);
  assign accept_evt = wr_evt && !stop && asm_pend && (pos != 2'd0)
                      && (idx == asm_idx) && (pos == asm_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_pend     <= 1'b0;
      asm_idx      <= '0;
      asm_next     <= 2'd0;
      asm_buf      <= '0;
      commit_valid <= 1'b0;
      commit_idx   <= '0;
      commit_value <= '0;
    end else begin
      commit_valid <= 1'b0;
      if (stop) begin
        asm_pend <= 1'b0;
      end else if (start_evt) begin
        asm_pend <= 1'b1;
        asm_idx  <= idx;
        asm_next <= 2'd1;
        asm_buf  <= put_byte('0, 2'd0, wdata);
      end else if (accept_evt) begin
        if (last) begin
          commit_valid <= 1'b1;
          commit_idx   <= asm_idx;
          commit_value <= put_byte(asm_buf, pos, wdata);
          asm_pend     <= 1'b0;
        end else begin
          asm_buf  <= put_byte(asm_buf, pos, wdata);
          asm_next <= asm_next + 2'd1;
        end
      end
    end
  end

  // R6: a commit always follows a write strobe
  a_r6_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wr_evt));
  // R6: commit lasts exactly one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);
  // R8: STOP leaves no assembly and no commit
  a_r8_stop_write: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !asm_pend && !commit_valid);
  // R9: low-byte write (re)starts assembly for the addressed register
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> asm_pend && asm_idx == $past(idx) && !commit_valid);
endmodule

// File: rtl/wide_byte_access.sv
module wide_byte_access
  import wab_pkg::*;
#(
  parameter int unsigned NWIDE  = 3,
  parameter int unsigned ADDR_W = 8,
  parameter logic [NWIDE*ADDR_W-1:0] BASE_MAP = {8'h30, 8'h20, 8'h10},
  parameter logic [NWIDE*2-1:0]      SIZE_MAP = {2'd3, 2'd2, 2'd3},
  localparam int unsigned IDX_W = (NWIDE > 1) ? $clog2(NWIDE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_wdata,
  input  logic                   bus_stop,
  input  logic [NWIDE*24-1:0]    live_flat,
  input  logic [7:0]             narrow_rdata,
  output logic [7:0]             rd_data,
  output logic                   thru_wr,
  output logic                   commit_valid,
  output logic [IDX_W-1:0]       commit_idx,
  output logic [23:0]            commit_value
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [1:0]       pos;
  logic             last;
  logic             held;
  logic [VAL_W-1:0] snap_val;
  logic [VAL_W-1:0] live_sel;
  logic             rd_evt;
  logic             wr_evt;

  wab_decode #(
    .NWIDE(NWIDE), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASE_MAP(BASE_MAP), .SIZE_MAP(SIZE_MAP)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .hit(hit), .idx(idx), .pos(pos), .last(last)
  );

  assign live_sel = live_flat[VAL_W*32'(idx) +: VAL_W];
  assign rd_evt   = bus_rd && hit;
  assign wr_evt   = bus_wr && hit;
  assign thru_wr  = bus_wr && !hit;

  wab_rd_snapshot #(.IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .idx(idx), .pos(pos),
    .last(last), .stop(bus_stop), .live_sel(live_sel),
    .held(held), .snap_val(snap_val)
  );

  wab_wr_assembler #(.IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .idx(idx), .pos(pos),
    .last(last), .wdata(bus_wdata), .stop(bus_stop),
    .commit_valid(commit_valid), .commit_idx(commit_idx),
    .commit_value(commit_value)
  );

  always_comb begin
    if (!hit)      rd_data = narrow_rdata;
    else if (held) rd_data = pick_byte(snap_val, pos);
    else           rd_data = pick_byte(live_sel, pos);
  end

  // R10: a pass-through write never produces a wide commit
  a_r10_narrow_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    thru_wr |=> !commit_valid);
  // R11: commit strobe is low in the first cycle after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !commit_valid);
endmodule

// File: tb/wide_byte_access_bench.sv
module wide_byte_access_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;
  localparam logic [2:0] OP_LIVE = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2, OP_STOP = 3'd3;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;  // register index for OP_LIVE
    logic [23:0] dat;
    logic [31:0] exp;   // rd: [7:0]; wr: {3'b0, valid, idx[3:0], value[23:0]}
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{OP_LIVE, 8'd0,  24'hA1B2C3, 32'h0, 4'd0},
    '{OP_LIVE, 8'd1,  24'h00D4E5, 32'h0, 4'd0},
    '{OP_LIVE, 8'd2,  24'h123456, 32'h0, 4'd0},
    '{OP_RD,   8'h11, 24'h0, 32'hB2, 4'd4},        // R4 no snapshot: live
    '{OP_RD,   8'h10, 24'h0, 32'hC3, 4'd2},        // R2 low byte live, capture
    '{OP_LIVE, 8'd0,  24'h112233, 32'h0, 4'd0},
    '{OP_RD,   8'h11, 24'h0, 32'hB2, 4'd3},        // R3 held middle
    '{OP_RD,   8'h12, 24'h0, 32'hA1, 4'd3},        // R3 held high, ends
    '{OP_RD,   8'h11, 24'h0, 32'h22, 4'd4},        // R4 live after end
    '{OP_RD,   8'h20, 24'h0, 32'hE5, 4'd2},        // R2 capture reg1
    '{OP_LIVE, 8'd1,  24'h009988, 32'h0, 4'd0},
    '{OP_RD,   8'h30, 24'h0, 32'h56, 4'd5},        // R5 replace snapshot
    '{OP_RD,   8'h21, 24'h0, 32'h99, 4'd5},        // R5 reg1 now live
    '{OP_LIVE, 8'd2,  24'h777777, 32'h0, 4'd0},
    '{OP_RD,   8'h31, 24'h0, 32'h34, 4'd3},        // R3 held reg2
    '{OP_STOP, 8'h0,  24'h0, 32'h0, 4'd0},
    '{OP_RD,   8'h32, 24'h0, 32'h77, 4'd8},        // R8 snapshot dropped
    '{OP_RD,   8'h05, 24'h0, 32'hFA, 4'd10},       // R10 narrow read
    '{OP_WR,   8'h10, 24'h11, 32'h0, 4'd6},        // R6 no commit on low
    '{OP_WR,   8'h11, 24'h22, 32'h0, 4'd7},        // R7 not complete
    '{OP_WR,   8'h12, 24'h33, 32'h10332211, 4'd6}, // R6 commit reg0 (R1 map)
    '{OP_WR,   8'h21, 24'h44, 32'h0, 4'd7},        // R7 high with nothing pending
    '{OP_WR,   8'h20, 24'h55, 32'h0, 4'd6},
    '{OP_WR,   8'h21, 24'h66, 32'h11006655, 4'd1}, // R1 two-byte reg, zero top
    '{OP_WR,   8'h30, 24'h01, 32'h0, 4'd6},
    '{OP_WR,   8'h32, 24'h02, 32'h0, 4'd7},        // R7 out of order ignored
    '{OP_WR,   8'h31, 24'h03, 32'h0, 4'd7},
    '{OP_WR,   8'h32, 24'h04, 32'h12040301, 4'd7}, // R7 pending kept
    '{OP_WR,   8'h10, 24'hAA, 32'h0, 4'd9},
    '{OP_WR,   8'h20, 24'hBB, 32'h0, 4'd9},        // R9 restart on reg1
    '{OP_WR,   8'h12, 24'hCC, 32'h0, 4'd9},        // R9 reg0 dropped
    '{OP_WR,   8'h21, 24'hDD, 32'h1100DDBB, 4'd9}, // R9 commit new reg
    '{OP_WR,   8'h30, 24'h10, 32'h0, 4'd8},
    '{OP_WR,   8'h31, 24'h20, 32'h0, 4'd8},
    '{OP_STOP, 8'h0,  24'h0, 32'h0, 4'd0},
    '{OP_WR,   8'h32, 24'h30, 32'h0, 4'd8}         // R8 partial write dropped
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_stop = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [71:0] live_flat = '0;
  logic [7:0]  narrow_rdata;
  logic [7:0]  rd_data;
  logic        thru_wr, commit_valid;
  logic [1:0]  commit_idx;
  logic [23:0] commit_value;
  int          n_chk = 0, n_bad = 0;

  assign narrow_rdata = ~bus_addr;
  always #(CLK_PERIOD/2) clk = ~clk;

  wide_byte_access u_wide_byte_access (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_stop(bus_stop),
    .live_flat(live_flat), .narrow_rdata(narrow_rdata), .rd_data(rd_data),
    .thru_wr(thru_wr), .commit_valid(commit_valid), .commit_idx(commit_idx),
    .commit_value(commit_value)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 chk(rd_data === e, tag, 32'(rd_data), 32'(e));
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input logic stp,
                       input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_stop = stp;
    @(posedge clk); #1 bus_wr = 1'b0; bus_stop = 1'b0;
    if (e[28])
      chk(commit_valid === 1'b1 && 32'(commit_idx) == 32'(e[27:24]) && commit_value === e[23:0],
          tag, {3'b0, commit_valid, 2'b0, commit_idx, commit_value}, e);
    else
      chk(commit_valid === 1'b0, tag, 32'(commit_valid), 32'h0);
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(posedge clk); #1 bus_stop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    chk(commit_valid === 1'b0, "R11 commit low after reset", 32'(commit_valid), 32'h0);
    chk(thru_wr === 1'b0, "R11 no write strobe idle", 32'(thru_wr), 32'h0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VECS[k].req, k);
      case (VECS[k].op)
        OP_LIVE: begin
          @(negedge clk);
          live_flat[24*int'(VECS[k].addr) +: 24] = VECS[k].dat;
        end
        OP_RD:   do_rd(VECS[k].addr, VECS[k].exp[7:0], tag);
        OP_WR:   do_wr(VECS[k].addr, VECS[k].dat[7:0], 1'b0, VECS[k].exp, tag);
        default: do_stop();
      endcase
    end

    // R10 pass-through and blocking of write strobe
    @(negedge clk); bus_addr = 8'h05; bus_wr = 1'b1; bus_wdata = 8'h5C;
    #1 chk(thru_wr === 1'b1, "R10 narrow write passes", 32'(thru_wr), 32'h1);
    bus_addr = 8'h11;
    #1 chk(thru_wr === 1'b0, "R10 wide write not passed", 32'(thru_wr), 32'h0);
    bus_addr = 8'h05;
    @(posedge clk); #1 bus_wr = 1'b0;
    chk(commit_valid === 1'b0, "R10 narrow write no commit", 32'(commit_valid), 32'h0);

    // R8 STOP together with high byte write suppresses commit
    do_wr(8'h20, 8'h71, 1'b0, 32'h0, "R8 low byte before stop");
    do_wr(8'h21, 8'h72, 1'b1, 32'h0, "R8 stop with high byte");
    do_wr(8'h21, 8'h73, 1'b0, 32'h0, "R8 nothing pending after stop");

    // R11 reset in the middle of a read snapshot
    live_flat[23:0] = 24'h445566;
    do_rd(8'h10, 8'h66, "R2 capture before reset");
    @(negedge clk); rst_n = 1'b0; live_flat[23:0] = 24'h998877;
    @(posedge clk); #1 rst_n = 1'b1;
    do_rd(8'h11, 8'h88, "R11 snapshot cleared by reset");
    do_wr(8'h12, 8'h01, 1'b0, 32'h0, "R11 no assembly after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule